// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block holds the configuration and status bytes of an eight-channel signal conditioner. The eight channels form two groups of four, A and B. A host reaches the bytes over a two-wire serial bus. The block is a target with a 7-bit address, it runs at standard rate, and it never stretches the clock. The system clock samples SCL and SDA through a short synchroniser and an edge detector. The block drives SDA through an open-drain enable, so SDA is either pulled low or released.

Each transfer starts at byte 0 and moves upward one byte at a time. There is no offset pointer. In a write, the first byte after the address byte is a placeholder, and the block throws it away. A host that wants to read from byte 0 may send that placeholder, issue a repeated START, and then read. While reset is high, the strap inputs load the control bytes. A lock input, sampled on every cycle, decides whether a bus write changes anything.

Top module: `sigcond_i2c_regs`

## Requirements
- R1: The block responds only to the address byte whose bits 7..1 equal {1, 1, addr_strap[2], 0, 0, addr_strap[1], addr_strap[0]}. Bit 0 of that byte selects read when it is 1. The block does not acknowledge any other address, and it ignores the rest of that transfer.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Either one releases SDA. Either one also returns the byte pointer to byte 0, so every transfer begins at byte 0.
- R3: The block pulls SDA low for the whole acknowledge clock that follows a matching address byte and each byte it receives. It changes its SDA drive only after SCL has fallen. It has no SCL output.
- R4: In a write, the block discards the first byte after the address byte. The bytes after that go to bytes 0, 1, 2 and onward, in that order.
- R5: A read returns byte 0 first and continues upward, with the most significant bit first. The host may stop after any complete byte by sending NACK and then STOP.
- R6: A write that carries only the placeholder byte, followed by a repeated START and a read address, returns data starting at byte 0.
- R7: The byte map is as follows.
  - Byte 2: bits 7..4 are the loopback controls for lanes 0..3, active low (lb_n[3]..lb_n[0]). Bit 3 is de_a and bit 2 is de_b.
  - Bytes 3, 4, 5, 6 and 7 hold input disable, output disable, channel reset (active low), channel power (active low) and receiver-detect enable. Each of these bytes orders its bits A0, B0, A1, B1, A2, B2, A3, B3 from bit 7 down to bit 0. Each byte appears unchanged on its output.
  - Bytes 8 and 9 hold the group A and group B settings. Each appears unchanged on grp_a_cfg or grp_b_cfg.
- R8: Byte 0 reads sig_det and byte 1 reads rx_det, both live. Byte 2 bits 1..0 read as 0. A write to any of these read-only bits has no effect, and the block still acknowledges the byte.
- R9: While rst is high, the bytes load from the straps, as follows. Strap changes made after reset have no effect.
  - Every loopback bit takes strap_lb_n. Every channel reset bit takes strap_rst_n. Every power bit takes strap_pd_n.
  - Byte 7 takes strap_rxd_a in its A bits and strap_rxd_b in its B bits.
  - de_a and de_b take their straps.
  - Bytes 8 and 9 take strap_grp_a and strap_grp_b.
  - Input disable and output disable take 0.
- R10: While mode_lock is high, the block still acknowledges written bytes, but no byte changes. mode_lock is not latched: once it goes low, writes take effect again.
- R11: Bytes 10 and 11 are reserved. They can be read and written, and they start at 0.
- R12: A read past byte 11 returns 0x00. A write past byte 11 is acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset; loads the straps |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_strap | input | 3 | Programmable address bits {A4, A1, A0} |
| mode_lock | input | 1 | High blocks all bus writes |
| strap_lb_n | input | 1 | Power-on value of every loopback bit |
| strap_pd_n | input | 1 | Power-on value of every channel power bit |
| strap_rst_n | input | 1 | Power-on value of every channel reset bit |
| strap_rxd_a | input | 1 | Power-on receiver-detect enable, group A |
| strap_rxd_b | input | 1 | Power-on receiver-detect enable, group B |
| strap_de_a | input | 1 | Power-on emphasis mode, group A |
| strap_de_b | input | 1 | Power-on emphasis mode, group B |
| strap_grp_a | input | 8 | Power-on value of byte 8 |
| strap_grp_b | input | 8 | Power-on value of byte 9 |
| sig_det | input | 8 | Live signal-detect status (byte 0) |
| rx_det | input | 8 | Live receiver-detect result (byte 1) |
| lb_n | output | 4 | Loopback control per lane pair, active low |
| de_a | output | 1 | Emphasis mode, group A |
| de_b | output | 1 | Emphasis mode, group B |
| in_dis | output | 8 | Input disable per channel |
| out_dis | output | 8 | Output disable per channel |
| ch_rst_n | output | 8 | Channel reset per channel, active low |
| ch_pd_n | output | 8 | Channel power per channel, active low |
| rxd_en | output | 8 | Receiver-detect enable per channel |
| grp_a_cfg | output | 8 | Group A equalizer, emphasis and swing setting |
| grp_b_cfg | output | 8 | Group B equalizer, emphasis and swing setting |

## Verification
The bench drives the following transfer patterns.
- A full block read straight after reset shows whether each byte lands at its own position and whether the straps loaded correctly. The thirteenth byte of that read shows whether a read past the end returns zero.
- A long write that includes the placeholder and runs past byte 11, read back through a combined write and repeated-START transfer, separates a dropped placeholder from a shifted byte map, and separates read-only bits from writable ones.
- Writes sent with the lock high, and then again with it low, show whether writes are blocked only while the lock is high.
- Short reads ended by NACK, and addresses that differ in one strapped bit or one fixed bit, show whether the pointer restarts at byte 0 and whether the address match is exact.

// File: rtl/sigcond_i2c_pkg.sv
package sigcond_i2c_pkg;

    localparam int NUM_REGS = 12;
    localparam int PTR_W    = $clog2(NUM_REGS + 1);
    localparam int NUM_RSVD = 2;

    localparam logic [PTR_W-1:0] REG_SIG   = 0;
    localparam logic [PTR_W-1:0] REG_RXDET = 1;
    localparam logic [PTR_W-1:0] REG_LBDE  = 2;
    localparam logic [PTR_W-1:0] REG_INDIS = 3;
    localparam logic [PTR_W-1:0] REG_ODIS  = 4;
    localparam logic [PTR_W-1:0] REG_CRST  = 5;
    localparam logic [PTR_W-1:0] REG_PWR   = 6;
    localparam logic [PTR_W-1:0] REG_RXEN  = 7;
    localparam logic [PTR_W-1:0] REG_GRPA  = 8;
    localparam logic [PTR_W-1:0] REG_GRPB  = 9;
    localparam logic [PTR_W-1:0] REG_RSV0  = 10;
    localparam logic [PTR_W-1:0] REG_RSV1  = 11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK
    } bus_state_e;

    typedef struct packed {
        logic             wr;
        logic [PTR_W-1:0] idx;
        logic [7:0]       data;
    } reg_wr_t;

    // Target address built from the three strapped bits {A4, A1, A0}
    function automatic logic [6:0] dev_addr(input logic [2:0] strap);
        return {2'b11, strap[2], 2'b00, strap[1:0]};
    endfunction

    // Byte pointer stops one past the last byte
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_REGS)) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/sigcond_bus_sync.sv
module sigcond_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_s, scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/sigcond_i2c_engine.sv
module sigcond_i2c_engine
    import sigcond_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             sda_s,
    input  logic [6:0]       dev_id,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output reg_wr_t          wr,
    output logic             sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd8;

    bus_state_e       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       sh;
    logic [PTR_W-1:0] ptr;
    logic             is_read;
    logic             skip_next;

    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        wr.wr <= 1'b0;
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            sh        <= '0;
            ptr       <= '0;
            is_read   <= 1'b0;
            skip_next <= 1'b0;
            sda_oe    <= 1'b0;
            wr.idx    <= '0;
            wr.data   <= '0;
        end else if (start_ev) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_ev) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh      <= {sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == LAST_BIT) begin
                        if (sh[7:1] == dev_id) begin
                            is_read <= sh[0];
                            sda_oe  <= 1'b1;
                            state   <= ST_AACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe    <= 1'b0;
                            skip_next <= 1'b1;
                            state     <= ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        sh      <= {sh[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == LAST_BIT) begin
                        sda_oe <= 1'b1;
                        state  <= ST_RACK;
                        if (skip_next) begin
                            skip_next <= 1'b0;
                        end else begin
                            wr.wr   <= 1'b1;
                            wr.idx  <= ptr;
                            wr.data <= sh;
                            ptr     <= ptr_next(ptr);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) state <= ST_IDLE;
                        else       ptr   <= ptr_next(ptr);
                    end else if (scl_fall) begin
                        sh      <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        bit_cnt <= '0;
                        state   <= ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sigcond_cfg_regfile.sv
module sigcond_cfg_regfile
    import sigcond_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_lock,
    input  reg_wr_t          wr,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             strap_lb_n,
    input  logic             strap_pd_n,
    input  logic             strap_rst_n,
    input  logic             strap_rxd_a,
    input  logic             strap_rxd_b,
    input  logic             strap_de_a,
    input  logic             strap_de_b,
    input  logic [7:0]       strap_grp_a,
    input  logic [7:0]       strap_grp_b,
    input  logic [7:0]       sig_det,
    input  logic [7:0]       rx_det,
    output logic [3:0]       lb_n,
    output logic             de_a,
    output logic             de_b,
    output logic [7:0]       in_dis,
    output logic [7:0]       out_dis,
    output logic [7:0]       ch_rst_n,
    output logic [7:0]       ch_pd_n,
    output logic [7:0]       rxd_en,
    output logic [7:0]       grp_a_cfg,
    output logic [7:0]       grp_b_cfg
);
    logic [7:0] rsv_q [NUM_RSVD];

    always_ff @(posedge clk) begin
        if (rst) begin
            lb_n      <= {4{strap_lb_n}};
            de_a      <= strap_de_a;
            de_b      <= strap_de_b;
            in_dis    <= '0;
            out_dis   <= '0;
            ch_rst_n  <= {8{strap_rst_n}};
            ch_pd_n   <= {8{strap_pd_n}};
            rxd_en    <= {4{strap_rxd_a, strap_rxd_b}};
            grp_a_cfg <= strap_grp_a;
            grp_b_cfg <= strap_grp_b;
            for (int i = 0; i < NUM_RSVD; i++) rsv_q[i] <= '0;
        end else if (wr.wr && !mode_lock) begin
            case (wr.idx)
                REG_LBDE:  {lb_n, de_a, de_b} <= wr.data[7:2];
                REG_INDIS: in_dis    <= wr.data;
                REG_ODIS:  out_dis   <= wr.data;
                REG_CRST:  ch_rst_n  <= wr.data;
                REG_PWR:   ch_pd_n   <= wr.data;
                REG_RXEN:  rxd_en    <= wr.data;
                REG_GRPA:  grp_a_cfg <= wr.data;
                REG_GRPB:  grp_b_cfg <= wr.data;
                REG_RSV0:  rsv_q[0]  <= wr.data;
                REG_RSV1:  rsv_q[1]  <= wr.data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            REG_SIG:   rd_data = sig_det;
            REG_RXDET: rd_data = rx_det;
            REG_LBDE:  rd_data = {lb_n, de_a, de_b, 2'b00};
            REG_INDIS: rd_data = in_dis;
            REG_ODIS:  rd_data = out_dis;
            REG_CRST:  rd_data = ch_rst_n;
            REG_PWR:   rd_data = ch_pd_n;
            REG_RXEN:  rd_data = rxd_en;
            REG_GRPA:  rd_data = grp_a_cfg;
            REG_GRPB:  rd_data = grp_b_cfg;
            REG_RSV0:  rd_data = rsv_q[0];
            REG_RSV1:  rd_data = rsv_q[1];
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/sigcond_i2c_regs.sv
module sigcond_i2c_regs
    import sigcond_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] addr_strap,
    input  logic       mode_lock,
    input  logic       strap_lb_n,
    input  logic       strap_pd_n,
    input  logic       strap_rst_n,
    input  logic       strap_rxd_a,
    input  logic       strap_rxd_b,
    input  logic       strap_de_a,
    input  logic       strap_de_b,
    input  logic [7:0] strap_grp_a,
    input  logic [7:0] strap_grp_b,
    input  logic [7:0] sig_det,
    input  logic [7:0] rx_det,
    output logic [3:0] lb_n,
    output logic       de_a,
    output logic       de_b,
    output logic [7:0] in_dis,
    output logic [7:0] out_dis,
    output logic [7:0] ch_rst_n,
    output logic [7:0] ch_pd_n,
    output logic [7:0] rxd_en,
    output logic [7:0] grp_a_cfg,
    output logic [7:0] grp_b_cfg
);
    logic             sda_s, scl_rise_ev, scl_fall_ev, start_ev, stop_ev;
    logic [PTR_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    reg_wr_t          wr;

    sigcond_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise_ev), .scl_fall(scl_fall_ev),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    sigcond_i2c_engine u_engine (
        .clk(clk), .rst(rst), .scl_rise(scl_rise_ev), .scl_fall(scl_fall_ev),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_s(sda_s),
        .dev_id(dev_addr(addr_strap)), .rd_data(rd_data),
        .rd_idx(rd_idx), .wr(wr), .sda_oe(sda_oe)
    );

    sigcond_cfg_regfile u_regs (
        .clk(clk), .rst(rst), .mode_lock(mode_lock), .wr(wr),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .strap_lb_n(strap_lb_n), .strap_pd_n(strap_pd_n),
        .strap_rst_n(strap_rst_n), .strap_rxd_a(strap_rxd_a),
        .strap_rxd_b(strap_rxd_b), .strap_de_a(strap_de_a),
        .strap_de_b(strap_de_b), .strap_grp_a(strap_grp_a),
        .strap_grp_b(strap_grp_b), .sig_det(sig_det), .rx_det(rx_det),
        .lb_n(lb_n), .de_a(de_a), .de_b(de_b), .in_dis(in_dis),
        .out_dis(out_dis), .ch_rst_n(ch_rst_n), .ch_pd_n(ch_pd_n),
        .rxd_en(rxd_en), .grp_a_cfg(grp_a_cfg), .grp_b_cfg(grp_b_cfg)
    );
endmodule

// File: rtl/sigcond_i2c_regs_chk.sv
module sigcond_i2c_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_lock,
    input logic       scl_fall_ev,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_oe,
    input logic [3:0] lb_n,
    input logic       de_a,
    input logic       de_b,
    input logic [7:0] in_dis,
    input logic [7:0] out_dis,
    input logic [7:0] ch_rst_n,
    input logic [7:0] ch_pd_n,
    input logic [7:0] rxd_en,
    input logic [7:0] grp_a_cfg,
    input logic [7:0] grp_b_cfg
);
    // R10: a locked cycle leaves every control byte unchanged
    a_r10_lock_freezes: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_lock)) |->
        $stable({lb_n, de_a, de_b, in_dis, out_dis, ch_rst_n, ch_pd_n,
                 rxd_en, grp_a_cfg, grp_b_cfg}));

    // R3: the block starts pulling SDA only right after an SCL fall
    a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall_ev));

    // R2: a START releases SDA
    a_r2_start_releases: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe);

    // R2: a STOP releases SDA
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe);
endmodule

bind sigcond_i2c_regs sigcond_i2c_regs_chk u_chk (
    .clk(clk), .rst(rst), .mode_lock(mode_lock), .scl_fall_ev(scl_fall_ev),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe), .lb_n(lb_n),
    .de_a(de_a), .de_b(de_b), .in_dis(in_dis), .out_dis(out_dis),
    .ch_rst_n(ch_rst_n), .ch_pd_n(ch_pd_n), .rxd_en(rxd_en),
    .grp_a_cfg(grp_a_cfg), .grp_b_cfg(grp_b_cfg)
);

// File: tb/tb_sigcond_i2c_regs.sv
module tb_sigcond_i2c_regs;
    localparam int QTR  = 10;
    localparam int WDOG = 150000;
    localparam logic [7:0] AW = 8'hE2;   // address 0x71 + write
    localparam logic [7:0] AR = 8'hE3;   // address 0x71 + read

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, scl_m, sda_m, sda_line, sda_oe, mode_lock;
    logic [2:0] addr_strap;
    logic strap_lb_n, strap_pd_n, strap_rst_n, strap_rxd_a, strap_rxd_b;
    logic strap_de_a, strap_de_b;
    logic [7:0] strap_grp_a, strap_grp_b, sig_det, rx_det;
    logic [3:0] lb_n;
    logic de_a, de_b;
    logic [7:0] in_dis, out_dis, ch_rst_n, ch_pd_n, rxd_en, grp_a_cfg, grp_b_cfg;

    assign sda_line = sda_m & ~sda_oe;

    sigcond_i2c_regs dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(addr_strap), .mode_lock(mode_lock),
        .strap_lb_n(strap_lb_n), .strap_pd_n(strap_pd_n),
        .strap_rst_n(strap_rst_n), .strap_rxd_a(strap_rxd_a),
        .strap_rxd_b(strap_rxd_b), .strap_de_a(strap_de_a),
        .strap_de_b(strap_de_b), .strap_grp_a(strap_grp_a),
        .strap_grp_b(strap_grp_b), .sig_det(sig_det), .rx_det(rx_det),
        .lb_n(lb_n), .de_a(de_a), .de_b(de_b), .in_dis(in_dis),
        .out_dis(out_dis), .ch_rst_n(ch_rst_n), .ch_pd_n(ch_pd_n),
        .rxd_en(rxd_en), .grp_a_cfg(grp_a_cfg), .grp_b_cfg(grp_b_cfg)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_b;
    event       got_ev;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // Monitor: pops one expected item per byte the design returns
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                chk("R5 unexpected byte", {24'h0, got_b}, 32'hFFFF_FFFF);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, {24'h0, got_b}, {24'h0, e});
            end
        end
    end

    task automatic hq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic clk_bit(input logic drv, output logic seen);
        sda_m = drv; hq();
        scl_m = 1'b1; hq();
        seen = sda_line; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq(); hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic send_acked(input logic [7:0] b, input string req);
        logic a;
        send_byte(b, a);
        chk(req, {31'h0, a}, 32'h1);
    endtask

    task automatic read_bytes(input int n);
        logic s;
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            for (int i = 7; i >= 0; i--) begin
                clk_bit(1'b1, s);
                b[i] = s;
            end
            clk_bit((k == n - 1) ? 1'b1 : 1'b0, s);
            got_b = b;
            ->got_ev;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; mode_lock = 1'b0;
        addr_strap = 3'b101;
        strap_lb_n = 1'b1; strap_pd_n = 1'b1; strap_rst_n = 1'b0;
        strap_rxd_a = 1'b1; strap_rxd_b = 1'b0;
        strap_de_a = 1'b1; strap_de_b = 1'b0;
        strap_grp_a = 8'hA5; strap_grp_b = 8'h3C;
        sig_det = 8'h96; rx_det = 8'h5A;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        strap_grp_a = 8'h00; strap_lb_n = 1'b0;   // later strap moves must not matter
        repeat (5) @(negedge clk);

        // R9 reset loads
        chk("R3 sda released after reset", {31'h0, sda_oe}, 0);
        chk("R9 lb_n", {28'h0, lb_n}, 32'hF);
        chk("R9 de", {30'h0, de_a, de_b}, 32'h2);
        chk("R9 in_dis/out_dis", {16'h0, in_dis, out_dis}, 0);
        chk("R9 ch_rst_n", {24'h0, ch_rst_n}, 32'h00);
        chk("R9 ch_pd_n", {24'h0, ch_pd_n}, 32'hFF);
        chk("R9 rxd_en", {24'h0, rxd_en}, 32'hAA);
        chk("R9 grp cfg", {16'h0, grp_a_cfg, grp_b_cfg}, 32'hA53C);

        // R5 full block read plus one past the end
        push_exp(8'h96, "R8 byte0 sig_det");
        push_exp(8'h5A, "R8 byte1 rx_det");
        push_exp(8'hF8, "R7 byte2 after reset");
        push_exp(8'h00, "R9 byte3");
        push_exp(8'h00, "R9 byte4");
        push_exp(8'h00, "R9 byte5");
        push_exp(8'hFF, "R9 byte6");
        push_exp(8'hAA, "R9 byte7");
        push_exp(8'hA5, "R9 byte8");
        push_exp(8'h3C, "R9 byte9");
        push_exp(8'h00, "R11 byte10 init");
        push_exp(8'h00, "R11 byte11 init");
        push_exp(8'h00, "R12 read past end");
        bus_start();
        send_acked(AR, "R1 read address acked");
        read_bytes(13);
        bus_stop();

        // R4 block write with placeholder, running past byte 11
        bus_start();
        send_acked(AW, "R1 write address acked");
        send_acked(8'hEE, "R4 placeholder acked");
        send_acked(8'h11, "R8 write to byte0 acked");
        send_acked(8'h22, "R8 write to byte1 acked");
        send_acked(8'h5F, "R3 byte2 acked");
        send_acked(8'hC3, "R3 byte3 acked");
        send_acked(8'h3C, "R3 byte4 acked");
        send_acked(8'hF0, "R3 byte5 acked");
        send_acked(8'h0F, "R3 byte6 acked");
        send_acked(8'h55, "R3 byte7 acked");
        send_acked(8'h12, "R3 byte8 acked");
        send_acked(8'h34, "R3 byte9 acked");
        send_acked(8'h9A, "R11 byte10 acked");
        send_acked(8'hBC, "R11 byte11 acked");
        send_acked(8'h77, "R12 write past end acked");
        bus_stop();
        chk("R2 SDA released after STOP", {31'h0, sda_line}, 32'h1);
        chk("R7 lb_n from byte2", {28'h0, lb_n}, 32'h5);
        chk("R7 de from byte2", {30'h0, de_a, de_b}, 32'h3);
        chk("R4 in_dis", {24'h0, in_dis}, 32'hC3);
        chk("R4 out_dis", {24'h0, out_dis}, 32'h3C);
        chk("R7 ch_rst_n", {24'h0, ch_rst_n}, 32'hF0);
        chk("R7 ch_pd_n", {24'h0, ch_pd_n}, 32'h0F);
        chk("R7 rxd_en", {24'h0, rxd_en}, 32'h55);
        chk("R7 grp cfg", {16'h0, grp_a_cfg, grp_b_cfg}, 32'h1234);

        // R6 combined transfer, status inputs live
        sig_det = 8'h3C; rx_det = 8'hC3;
        push_exp(8'h3C, "R6 byte0 live sig_det");
        push_exp(8'hC3, "R6 byte1 live rx_det");
        push_exp(8'h5C, "R8 byte2 reserved bits read 0");
        push_exp(8'hC3, "R6 byte3");
        push_exp(8'h3C, "R6 byte4");
        push_exp(8'hF0, "R6 byte5");
        push_exp(8'h0F, "R6 byte6");
        push_exp(8'h55, "R6 byte7");
        push_exp(8'h12, "R6 byte8");
        push_exp(8'h34, "R6 byte9");
        push_exp(8'h9A, "R11 byte10 written");
        push_exp(8'hBC, "R11 byte11 written");
        bus_start();
        send_acked(AW, "R6 write address acked");
        send_acked(8'h00, "R6 placeholder acked");
        bus_start();
        send_acked(AR, "R6 read address after repeated START");
        read_bytes(12);
        bus_stop();

        // R10 locked write is acked but changes nothing
        mode_lock = 1'b1;
        bus_start();
        send_acked(AW, "R10 address acked while locked");
        send_acked(8'h00, "R10 placeholder acked");
        for (int i = 0; i < 5; i++) send_acked(8'hFF, "R10 data acked while locked");
        bus_stop();
        chk("R10 in_dis unchanged", {24'h0, in_dis}, 32'hC3);
        chk("R10 out_dis unchanged", {24'h0, out_dis}, 32'h3C);
        chk("R10 lb_n unchanged", {28'h0, lb_n}, 32'h5);
        mode_lock = 1'b0;
        bus_start();
        send_acked(AW, "R10 address acked after unlock");
        send_acked(8'h00, "R10 placeholder");
        send_acked(8'h00, "R10 byte0");
        send_acked(8'h00, "R10 byte1");
        send_acked(8'h5F, "R10 byte2");
        send_acked(8'h81, "R10 byte3");
        bus_stop();
        chk("R10 write effective after unlock", {24'h0, in_dis}, 32'h81);

        // R5 early NACK, then pointer restarts at byte 0 (R2)
        push_exp(8'h3C, "R5 single byte read");
        bus_start();
        send_acked(AR, "R5 address");
        read_bytes(1);
        bus_stop();
        push_exp(8'h3C, "R2 restart byte0");
        push_exp(8'hC3, "R2 restart byte1");
        push_exp(8'h5C, "R2 restart byte2");
        push_exp(8'h81, "R2 restart byte3");
        bus_start();
        send_acked(AR, "R2 address");
        read_bytes(4);
        bus_stop();

        // R1 wrong addresses are ignored
        bus_start();
        send_byte(8'hE0, a);
        chk("R1 wrong strapped bit not acked", {31'h0, a}, 0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        chk("R1 data after foreign address not acked", {31'h0, a}, 0);
        bus_stop();
        chk("R1 foreign write left in_dis", {24'h0, in_dis}, 32'h81);
        bus_start();
        send_byte(8'hF2, a);
        chk("R1 wrong fixed bit not acked", {31'h0, a}, 0);
        bus_stop();

        hq();
        chk("R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule